// File: doc/BRIEF.md
# Synchronizable Multi-Output Clock Divider

This block derives several divided clocks from one input clock. Each output channel has its own divide ratio, phase word and enable. An active-low sync request realigns the channel counters, so that every divided output starts from a known position relative to the same input clock edge. Software-visible configuration arrives on plain register inputs that are already decoded.

The sync input is captured asynchronously. A pulse narrower than a clock period is still recorded, and a pulse that arrives while the input clock is stopped is held until clock edges resume. The first rising edge that sees the pending request opens a window of four input cycles. During that window the divided outputs are held low. On the last edge of the window, each enabled channel loads its ratio and phase. A channel whose ratio is one bypasses its counter and passes the input clock through. A disabled channel is held low and its counter is held in reset.

Top module: `mcd_top`

## Requirements
- R1: A low level on `sync_n` sets a pending request asynchronously, without a clock edge. The request is held while the clock is stopped and acts on the first rising edge after the clock resumes.
- R2: Call the first rising edge that sees a pending request E0. Channel counters realign on edge E4, which is the fourth rising edge after E0.
- R3: From E0 up to E4, every enabled channel with a divide ratio above one drives its output low.
- R4: A new request arriving during the window restarts it. The edge that sees the new request becomes the new E0.
- R5: The divide ratio is N = `ratio_code` + 1, giving N from 1 to 32. In each period of N input cycles the divided output is high for floor(N/2) cycles, starting at counter position 0.
- R6: Let p be `phase_word` mod N. After rising edge E4+k, the output is high exactly when ((k − p) mod N) < floor(N/2). As a result, the first rising edge of a period lands p cycles after E4.
- R7: A channel whose latched `ratio_code` is 0 drives `clk_out` equal to `clk_in`. The sync window does not affect it.
- R8: When `out_en` is low, the channel output is low and its counter is held at position 0.
- R9: New `ratio_code` and `phase_word` values take effect only on a realignment edge. Until then, the output keeps the waveform of the previously latched setting.
- R10: While `rst` is high, all outputs are low and any window is cleared. Each channel latches its live ratio and sets its counter to position 0. After release, each channel runs as if its phase were 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| sync_n | input | 1 | Active-low sync request, captured asynchronously |
| out_en | input | NUM_OUT | Per-channel enable |
| ratio_code | input | NUM_OUT x 5 | Per-channel divide code, ratio = code + 1 |
| phase_word | input | NUM_OUT x 5 | Per-channel phase offset in input cycles |
| clk_out | output | NUM_OUT | Divided or bypassed clock outputs |

## Verification
The bench builds the block with its default values: three channels, a four-cycle sync delay and 5-bit ratio and phase fields. With these values a single configuration can mix even ratios, odd ratios, the largest ratio of 32, bypass and disabled channels. Because the phase field reaches 31, phase words larger than a small ratio are reachable, which exercises the modulo reduction. The directed cases cover the following:
- a request made while the clock is stopped
- a request that restarts an open window
- a ratio change made without a sync
- a mid-run disable and a mid-run reset

// File: rtl/mcd_pkg.sv
`timescale 1ns/1ps
package mcd_pkg;

    parameter int RATIO_W = 5;
    parameter int PHASE_W = 5;
    localparam int DIV_W  = RATIO_W + 1;

    typedef logic [RATIO_W-1:0] ratio_t;
    typedef logic [PHASE_W-1:0] phase_t;
    typedef logic [RATIO_W-1:0] pos_t;
    typedef logic [DIV_W-1:0]   div_t;

    // live per-channel configuration
    typedef struct packed {
        logic   en;
        ratio_t code;
        phase_t phase;
    } chan_cfg_t;

    // latched divider setting
    typedef struct packed {
        div_t n;
        div_t half;
        logic byp;
    } div_set_t;

    function automatic div_set_t decode_ratio(ratio_t code);
        div_set_t d;
        d.n    = DIV_W'(code) + DIV_W'(1);
        d.half = d.n >> 1;
        d.byp  = (code == '0);
        return d;
    endfunction

    // counter preload so that the period start lands phase mod N cycles later
    function automatic pos_t start_pos(ratio_t code, phase_t ph);
        div_t n;
        div_t pm;
        n  = DIV_W'(code) + DIV_W'(1);
        pm = DIV_W'(ph) % n;
        if (pm == '0) return '0;
        return pos_t'(n - pm);
    endfunction

endpackage

// File: rtl/mcd_sync_ctrl.sv
`timescale 1ns/1ps
module mcd_sync_ctrl #(
    parameter int SYNC_DLY = 4,
    parameter int WIN_W    = $clog2(SYNC_DLY + 1)
) (
    input  logic             clk_in,
    input  logic             rst,
    input  logic             sync_n,
    output logic             req_q,
    output logic [WIN_W-1:0] win_cnt,
    output logic             realign,
    output logic             hold
);

    // request flag: set without a clock, consumed by the next clock edge
    always_ff @(posedge clk_in or negedge sync_n) begin
        if (!sync_n) req_q <= 1'b1;
        else         req_q <= 1'b0;
    end

    always_ff @(posedge clk_in) begin
        if (rst)                 win_cnt <= '0;
        else if (req_q)          win_cnt <= WIN_W'(SYNC_DLY);
        else if (win_cnt != '0)  win_cnt <= win_cnt - 1'b1;
    end

    assign hold    = (win_cnt != '0);
    assign realign = (win_cnt == WIN_W'(1)) && !req_q;

endmodule

// File: rtl/mcd_chan.sv
`timescale 1ns/1ps
module mcd_chan
    import mcd_pkg::*;
(
    input  logic      clk_in,
    input  logic      rst,
    input  logic      realign,
    input  logic      hold,
    input  chan_cfg_t cfg,
    output logic      clk_out,
    output logic      div_active
);

    div_set_t sh;
    pos_t     pos;

    always_ff @(posedge clk_in) begin
        if (rst) begin
            sh  <= decode_ratio(cfg.code);
            pos <= '0;
        end else if (!cfg.en) begin
            pos <= '0;
        end else if (realign) begin
            sh  <= decode_ratio(cfg.code);
            pos <= start_pos(cfg.code, cfg.phase);
        end else if (DIV_W'(pos) == sh.n - DIV_W'(1)) begin
            pos <= '0;
        end else begin
            pos <= pos + 1'b1;
        end
    end

    always_comb begin
        if (rst || !cfg.en) clk_out = 1'b0;
        else if (sh.byp)    clk_out = clk_in;
        else                clk_out = !hold && (DIV_W'(pos) < sh.half);
    end

    assign div_active = cfg.en && !sh.byp;

endmodule

// File: rtl/mcd_top.sv
`timescale 1ns/1ps
module mcd_top
    import mcd_pkg::*;
#(
    parameter int NUM_OUT  = 3,
    parameter int SYNC_DLY = 4
) (
    input  logic                              clk_in,
    input  logic                              rst,
    input  logic                              sync_n,
    input  logic [NUM_OUT-1:0]                out_en,
    input  logic [NUM_OUT-1:0][RATIO_W-1:0]   ratio_code,
    input  logic [NUM_OUT-1:0][PHASE_W-1:0]   phase_word,
    output logic [NUM_OUT-1:0]                clk_out
);

    localparam int WIN_W = $clog2(SYNC_DLY + 1);

    logic             req_q;
    logic [WIN_W-1:0] win_cnt;
    logic             realign;
    logic             hold;
    logic [NUM_OUT-1:0] div_active;

    mcd_sync_ctrl #(.SYNC_DLY(SYNC_DLY), .WIN_W(WIN_W)) sync_i (
        .clk_in  (clk_in),
        .rst     (rst),
        .sync_n  (sync_n),
        .req_q   (req_q),
        .win_cnt (win_cnt),
        .realign (realign),
        .hold    (hold)
    );

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_chan
        chan_cfg_t cfg;
        assign cfg.en    = out_en[g];
        assign cfg.code  = ratio_code[g];
        assign cfg.phase = phase_word[g];

        mcd_chan chan_i (
            .clk_in     (clk_in),
            .rst        (rst),
            .realign    (realign),
            .hold       (hold),
            .cfg        (cfg),
            .clk_out    (clk_out[g]),
            .div_active (div_active[g])
        );
    end

endmodule

// File: rtl/mcd_chk.sv
`timescale 1ns/1ps
module mcd_chk #(
    parameter int NUM_OUT  = 3,
    parameter int SYNC_DLY = 4,
    parameter int WIN_W    = 3
) (
    input logic               clk_in,
    input logic               rst,
    input logic               sync_n,
    input logic               req_q,
    input logic [WIN_W-1:0]   win_cnt,
    input logic [NUM_OUT-1:0] div_active,
    input logic [NUM_OUT-1:0] out_en,
    input logic [NUM_OUT-1:0] clk_out
);

    // R1
    req_captured_chk: assert property (@(posedge clk_in) disable iff (rst)
        !sync_n |-> req_q);

    // R4
    window_restart_chk: assert property (@(posedge clk_in) disable iff (rst)
        req_q |=> (win_cnt == WIN_W'(SYNC_DLY)));

    // R2
    window_count_chk: assert property (@(posedge clk_in) disable iff (rst)
        (win_cnt != '0 && !req_q) |=> (win_cnt == $past(win_cnt) - 1'b1));

    // R3
    window_hold_chk: assert property (@(posedge clk_in) disable iff (rst)
        (win_cnt != '0) |-> ((clk_out & div_active) == '0));

    for (genvar g = 0; g < NUM_OUT; g++) begin : g_dis
        // R8
        disabled_low_chk: assert property (@(posedge clk_in) disable iff (rst)
            !out_en[g] |-> !clk_out[g]);
    end

endmodule

bind mcd_top mcd_chk #(.NUM_OUT(NUM_OUT), .SYNC_DLY(SYNC_DLY), .WIN_W(WIN_W)) chk_i (
    .clk_in     (clk_in),
    .rst        (rst),
    .sync_n     (sync_n),
    .req_q      (req_q),
    .win_cnt    (win_cnt),
    .div_active (div_active),
    .out_en     (out_en),
    .clk_out    (clk_out)
);

// File: tb/mcd_top_tb.sv
`timescale 1ns/1ps
module mcd_top_tb_top;

    typedef struct packed {
        logic [2:0]      en;
        logic [2:0][4:0] code;
        logic [2:0][4:0] ph;
    } vec_t;

    // configurations, channel 2 first inside each packed field
    localparam vec_t VEC [6] = '{
        '{3'b111, {5'd3,  5'd3, 5'd3},  {5'd2,  5'd1, 5'd0}},
        '{3'b111, {5'd6,  5'd2, 5'd4},  {5'd3,  5'd7, 5'd0}},
        '{3'b111, {5'd0,  5'd1, 5'd31}, {5'd0,  5'd1, 5'd5}},
        '{3'b101, {5'd2,  5'd9, 5'd5},  {5'd30, 5'd0, 5'd2}},
        '{3'b111, {5'd15, 5'd7, 5'd0},  {5'd17, 5'd8, 5'd0}},
        '{3'b111, {5'd1,  5'd1, 5'd1},  {5'd1,  5'd1, 5'd0}}
    };

    logic            clk_in = 1'b0;
    logic            clk_run = 1'b1;
    logic            rst;
    logic            sync_n;
    logic [2:0]      out_en;
    logic [2:0][4:0] ratio_code;
    logic [2:0][4:0] phase_word;
    logic [2:0]      clk_out;

    int checks = 0;
    int errors = 0;
    vec_t model;

    mcd_top dut_i (
        .clk_in     (clk_in),
        .rst        (rst),
        .sync_n     (sync_n),
        .out_en     (out_en),
        .ratio_code (ratio_code),
        .phase_word (phase_word),
        .clk_out    (clk_out)
    );

    always begin
        #2.5;
        if (clk_run) clk_in = ~clk_in;
    end

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_out(logic en, logic [4:0] code, logic [4:0] ph, int k);
        int n, pm;
        if (!en || code == 0) return 0;
        n  = int'(code) + 1;
        pm = int'(ph) % n;
        return (((k - pm) % n + n) % n) < (n / 2) ? 1 : 0;
    endfunction

    task automatic set_cfg(vec_t v);
        out_en     = v.en;
        ratio_code = v.code;
        phase_word = v.ph;
    endtask

    task automatic pulse_sync();
        @(negedge clk_in);
        sync_n = 1'b0;
        #1 sync_n = 1'b1;
    endtask

    // starts just after E0, ends just after E4
    task automatic win_e4(string req);
        int bad = 0;
        int seen = 0;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk_in);
            if (clk_out != 3'b000) begin bad++; seen = clk_out; end
            @(posedge clk_in);
        end
        chk(bad == 0, req, "outputs in sync window", seen, 0);
    endtask

    // sample at negedges after edges E4+k0 .. E4+k0+cyc-1
    task automatic track(string req, int k0, int cyc);
        int bad [3];
        int fa [3];
        int fe [3];
        for (int i = 0; i < 3; i++) bad[i] = 0;
        for (int k = k0; k < k0 + cyc; k++) begin
            @(negedge clk_in);
            for (int i = 0; i < 3; i++) begin
                int e;
                e = exp_out(model.en[i], model.code[i], model.ph[i], k);
                if (int'(clk_out[i]) != e) begin
                    if (bad[i] == 0) begin fa[i] = clk_out[i]; fe[i] = e; end
                    bad[i]++;
                end
            end
        end
        for (int i = 0; i < 3; i++)
            chk(bad[i] == 0, req, $sformatf("channel %0d waveform", i), fa[i], fe[i]);
    endtask

    initial begin
        #(200000 * 5);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst    = 1'b1;
        sync_n = 1'b1;
        set_cfg(VEC[0]);
        repeat (3) @(posedge clk_in);
        @(negedge clk_in);
        // R10: outputs low in reset
        chk(clk_out == 3'b000, "R10", "outputs during reset", clk_out, 0);
        rst   = 1'b0;
        model = VEC[0];
        model.ph = '0;
        track("R10", 1, 12);

        // R2 R3 R5 R6: table of configurations
        for (int v = 0; v < 6; v++) begin
            set_cfg(VEC[v]);
            pulse_sync();
            @(posedge clk_in);
            win_e4("R2 R3");
            model = VEC[v];
            track("R5 R6", 0, 70);
        end

        // R9: new ratio without sync keeps old waveform
        ratio_code = VEC[0].code;
        phase_word = VEC[0].ph;
        track("R9", 70, 24);
        pulse_sync();
        @(posedge clk_in);
        win_e4("R9");
        model = VEC[0];
        track("R9", 0, 24);

        // R4: second request inside the window restarts it
        set_cfg(VEC[1]);
        pulse_sync();
        @(posedge clk_in);
        @(negedge clk_in);
        chk(clk_out == 3'b000, "R4", "outputs after first E0", clk_out, 0);
        @(posedge clk_in);
        pulse_sync();
        @(posedge clk_in);
        win_e4("R4");
        model = VEC[1];
        track("R4", 0, 40);

        // R1: request while the clock is stopped
        set_cfg(VEC[2]);
        @(negedge clk_in);
        clk_run = 1'b0;
        #3 sync_n = 1'b0;
        #1 sync_n = 1'b1;
        #30 clk_run = 1'b1;
        @(posedge clk_in);
        win_e4("R1");
        model = VEC[2];
        track("R1", 0, 70);

        // R7: bypass follows the clock even inside the window
        out_en     = 3'b111;
        ratio_code = {5'd3, 5'd1, 5'd0};
        phase_word = '0;
        pulse_sync();
        @(posedge clk_in);
        win_e4("R7");
        begin
            int bad = 0;
            pulse_sync();
            for (int j = 0; j < 6; j++) begin
                @(posedge clk_in);
                #1 if (clk_out[0] !== 1'b1) bad++;
                @(negedge clk_in);
                #1 if (clk_out[0] !== 1'b0) bad++;
            end
            chk(bad == 0, "R7", "bypass mismatches", bad, 0);
        end
        repeat (4) @(posedge clk_in);

        // R8: disable mid-run, and a sync while disabled
        set_cfg(VEC[0]);
        pulse_sync();
        @(posedge clk_in);
        win_e4("R8");
        model = VEC[0];
        track("R8", 0, 8);
        begin
            int bad = 0;
            out_en[1] = 1'b0;
            pulse_sync();
            for (int j = 0; j < 12; j++) begin
                @(posedge clk_in);
                #1 if (clk_out[1] !== 1'b0) bad++;
                @(negedge clk_in);
                #1 if (clk_out[1] !== 1'b0) bad++;
            end
            chk(bad == 0, "R8", "disabled output high samples", bad, 0);
        end

        // R10: reset mid-run
        out_en = 3'b111;
        @(negedge clk_in);
        rst = 1'b1;
        repeat (2) @(posedge clk_in);
        @(negedge clk_in);
        chk(clk_out == 3'b000, "R10", "outputs in mid-run reset", clk_out, 0);
        rst   = 1'b0;
        model = VEC[0];
        model.ph = '0;
        track("R10", 1, 16);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule